// File: doc/BRIEF.md
# Vertical-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands and returns the full double-width product. It is purely combinational, with no clock, no state and no handshake. It can sit on any datapath that needs a one-pass multiply. The result is valid as soon as the logic has settled after an operand change.

Each leaf cell is a small square core, 4x4 by default. The core builds its product one column at a time. Column k adds every bit pair whose indices sum to k, plus the carry from column k-1. The full width is then built in doubling stages. Each stage splits both operands into high and low halves and takes four half-size products: high·high, high·low, low·high and low·low. It adds them at offsets of a full width, half a width, half a width and zero. With the defaults, three such stages turn 64 leaf cores into one 32x32 multiply.

Top module: `vc_mult`

## Requirements
- R1: `prod` equals the unsigned product of `a` and `b`, all 64 bits kept.
- R2: If either operand is zero, `prod` is zero.
- R3: If one operand is 1, `prod` equals the other operand zero-extended to 64 bits.
- R4: Two all-ones operands give 64'hFFFF_FFFE_0000_0001, with no truncation of the upper half.
- R5: Bit 0 of `prod` is the AND of `a[0]` and `b[0]`.
- R6: If both operands are below 2^16, bits 63:32 of `prod` are zero.
- R7: `a` shifted left by i places (a single set bit at position i), multiplied by `b`, gives `b` shifted left by i.
- R8: For operands below 16, which reach only one leaf core, `prod` is the exact product and never exceeds 225.
- R9: `prod` depends on the present operands only and holds no state: it updates within the cycle of an operand change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W (32) | Unsigned multiplicand |
| b | input | W (32) | Unsigned multiplier |
| prod | output | 2*W (64) | Unsigned full-width product |

## Verification
Every operand pair below 16 is tried. This exercises the column sums and carries of a single leaf core on its own. Zero, one and all-ones operands on either side test the extremes. They show whether the top carry reaches bit 63 and whether a missing term is masked by a zero. Walking single bits place one operand at every offset, so a high or middle product added at the wrong shift shows up. Ten thousand random pairs, compared against the built-in operator, catch faults in column sums and stage adds that only particular bit mixes reveal.

// File: rtl/vc_mult.sv
module vc_mult #(
  parameter int W    = 32,
  parameter int CORE = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int NB   = W / CORE;
  localparam int LV   = $clog2(NB);
  localparam int CMAX = ((1 << CORE) - 1) * ((1 << CORE) - 1);

  function automatic logic [2*CORE-1:0] col_core(input logic [CORE-1:0] x, input logic [CORE-1:0] y);
    logic [2*CORE-1:0] r;
    int unsigned acc;
    acc = 0;
    r = '0;
    for (int k = 0; k < 2*CORE-1; k++) begin
      for (int i = 0; i < CORE; i++) begin
        if (k - i >= 0 && k - i < CORE)
          acc = acc + {31'b0, x[i] & y[k-i]};
      end
      r[k] = acc[0];
      acc = acc >> 1;
    end
    r[2*CORE-1] = acc[0];
    return r;
  endfunction

  for (genvar L = 0; L <= LV; L++) begin : lev
    localparam int S = CORE << L;
    localparam int N = NB >> L;
    logic [2*S-1:0] pr [N][N];
    for (genvar i = 0; i < N; i++) begin : row
      for (genvar j = 0; j < N; j++) begin : col
        if (L == 0) begin : leaf
          assign pr[i][j] = col_core(a[i*CORE +: CORE], b[j*CORE +: CORE]);
          always_comb
            p_core_bound_r8: assert (pr[i][j] <= (2*S)'(CMAX))
              else $error("core product out of range");
        end else begin : join2
          logic [S-1:0]   hh, hl, lh, ll;
          logic [S:0]     mid;
          logic [2*S-1:0] mid_sh;
          assign hh     = lev[L-1].pr[2*i+1][2*j+1];
          assign hl     = lev[L-1].pr[2*i+1][2*j];
          assign lh     = lev[L-1].pr[2*i][2*j+1];
          assign ll     = lev[L-1].pr[2*i][2*j];
          assign mid    = {1'b0, hl} + {1'b0, lh};
          assign mid_sh = {{(S-1){1'b0}}, mid} << (S/2);
          assign pr[i][j] = {hh, ll} + mid_sh;
        end
      end
    end
  end

  assign prod = lev[LV].pr[0][0];

  always_comb begin
    p_zero_operand_r2: assert (!(a == '0 || b == '0) || prod == '0)
      else $error("zero operand gave nonzero product");
    p_unit_operand_r3: assert (a != W'(1) || prod == {{W{1'b0}}, b})
      else $error("unit operand mismatch");
    p_low_bit_r5: assert (prod[0] == (a[0] & b[0]))
      else $error("product bit 0 wrong");
    p_no_overflow_r6: assert (!(a[W-1:W/2] == '0 && b[W-1:W/2] == '0) || prod[2*W-1:W] == '0)
      else $error("upper half set for half-width operands");
  end
endmodule

// File: tb/vc_mult_test.sv
module vc_mult_test;
  localparam int W = 32;
  localparam int NV = 8;
  localparam logic [W-1:0]   VA [NV] = '{32'h0000_0003, 32'h0001_0000, 32'h0000_FFFF, 32'hFFFF_FFFF,
                                         32'h8000_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'hFFFF_FFFF};
  localparam logic [W-1:0]   VB [NV] = '{32'h0000_0005, 32'h0001_0000, 32'h0000_FFFF, 32'h0000_0002,
                                         32'h8000_0000, 32'h0001_0001, 32'h0000_0010, 32'hFFFF_FFFF};
  localparam logic [2*W-1:0] VP [NV] = '{64'h0000_0000_0000_000F, 64'h0000_0001_0000_0000,
                                         64'h0000_0000_FFFE_0001, 64'h0000_0001_FFFF_FFFE,
                                         64'h4000_0000_0000_0000, 64'h0000_0001_0000_FFFE_FFFF,
                                         64'h0000_0000_F0F0_F0F0, 64'hFFFF_FFFE_0000_0001};

  logic clk = 0;
  logic [W-1:0] a = '0, b = '0;
  logic [2*W-1:0] prod;
  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vc_mult #(.W(W), .CORE(4)) uut (.a(a), .b(b), .prod(prod));

  task automatic check(input string tag, input logic [2*W-1:0] exp);
    nchk++;
    if (prod !== exp) begin
      nfail++;
      $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a, b, prod, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    a = x;
    b = y;
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #1;
    check("R2 initial zero operands", 64'h0);

    for (int v = 0; v < NV; v++) begin
      apply(VA[v], VB[v]);
      check((v == NV-1) ? "R4 all-ones squared" : "R1 vector table", VP[v]);
    end

    apply('0, 32'hDEAD_BEEF); check("R2 zero a", 64'h0);
    apply(32'hFFFF_FFFF, '0); check("R2 zero b", 64'h0);
    apply(32'd1, 32'hCAFE_F00D); check("R3 unit a", 64'h0000_0000_CAFE_F00D);
    apply(32'hFFFF_FFFF, 32'd1); check("R3 unit b", 64'h0000_0000_FFFF_FFFF);

    for (int i = 0; i < W; i++) begin
      apply(32'd1 << i, 32'hA5C3_96E1);
      check("R7 walking one a", {32'h0, 32'hA5C3_96E1} << i);
      apply(32'hFFFF_FFFF, 32'd1 << i);
      check("R7 walking one b", {32'h0, 32'hFFFF_FFFF} << i);
    end

    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        apply(W'(x), W'(y));
        check("R8 single core", 64'(x * y));
      end

    apply(32'h0000_FFFF, 32'h0000_FFFF);
    check("R6 upper half zero", {32'h0, prod[31:0]});
    apply(32'h0000_0003, 32'hFFFF_FFFF);
    check("R5 low bit", {prod[63:1], 1'b1});

    for (int n = 0; n < 10000; n++) begin
      logic [W-1:0] x, y;
      x = $urandom;
      y = $urandom;
      apply(x, y);
      check("R1 random", {32'h0, x} * {32'h0, y});
    end

    @(negedge clk);
    a = 32'h1234_5678;
    b = 32'h0000_0100;
    #0.5;
    check("R9 settles without clock edge", 64'h0000_0012_3456_7800);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule